// File: doc/BRIEF.md
# Indexed Real-Time-Clock Host Register Port

This block is the host-side register front end of a real-time clock. A host reaches two byte-wide register windows, each through an index/data pair: it first writes a register number to the index offset, then reads or writes the selected byte at the data offset. Window 0 holds the control registers, the interrupt flag register, the power-status register and general-purpose battery-backed RAM. Window 1 is a plain extended byte bank.

The block latches periodic, alarm and update event pulses from the time-keeping logic into a flag register. Reading that register clears all of its flags. The most significant bit of the flag byte summarises the flags that are enabled in control register B, and the same value drives the interrupt request pin. The divider and the counters are outside this block. They take the control register contents from two output buses and report their update-in-progress state on one input pin.

Top module: `rtc_host_port`

## Requirements
- R1: Writing offset 0 stores an 8-bit index that reads back at offset 0. Offset 1 then writes or reads the window-0 byte that index bits 6:0 select.
- R2: Offsets 2 (index) and 3 (data) reach window 1, which is separate storage. A window-0 write never changes a window-1 byte, even at the same index.
- R3: Flag register C (index 0x0C) latches the periodic event at bit 6, the alarm event at bit 5 and the update event at bit 4, whether or not that event is enabled. Bits 3:0 read 0.
- R4: Bit 7 of register C is set when any flag is set together with its enable in register B (periodic enable at bit 6, alarm at bit 5, update at bit 4). irq_o is active high and always equals that bit.
- R5: A read of register C returns the flags held before the read and clears all of them at that clock edge.
- R6: An event pulse in the same cycle as a read of register C is not lost. It appears in the next read.
- R7: Register D (index 0x0D) always reads 0x80 (valid RAM and time). Writes to registers C and D have no effect.
- R8: In register A (index 0x0A), bit 7 reads the uip_i pin and ignores writes. Bits 6:0 are read/write and drive ctrl_a_o. Register B (index 0x0B) is read/write and drives ctrl_b_o.
- R9: Window-0 indexes 0x0F to 0x7F hold general-purpose bytes. Index bit 7 does not take part in selection, so 0x80+n reaches the same byte as n.
- R10: After a synchronous reset, both indexes, all stored bytes, ctrl_a_o, ctrl_b_o, the flags and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Port offset: 0/1 index/data of window 0, 2/3 index/data of window 1 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; a read of register C clears the flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, valid in the same cycle |
| uip_i | input | 1 | Update-in-progress level from the time-keeping logic |
| ev_periodic_i | input | 1 | Periodic event pulse |
| ev_alarm_i | input | 1 | Alarm match pulse |
| ev_update_i | input | 1 | Update-complete pulse |
| ctrl_a_o | output | 7 | Register A bits 6:0 (divider and rate select) |
| ctrl_b_o | output | 8 | Register B contents |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions take two things for granted. First, a read strobe arrives with a stable offset and is never combined with a write in the same cycle. Second, event pulses are single-cycle levels from synchronous logic. The bench issues every access through tasks that raise exactly one strobe for one cycle. Random events are injected only between accesses. The one case where an event coincides with a flag read is a dedicated directed test. The random mix writes and reads random indexes in both windows, including registers A to D. Every returned byte is compared with a reference model held in the bench.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

    localparam int REG_IDX_W = 7;

    localparam logic [REG_IDX_W-1:0] REG_A = 7'h0A;
    localparam logic [REG_IDX_W-1:0] REG_B = 7'h0B;
    localparam logic [REG_IDX_W-1:0] REG_C = 7'h0C;
    localparam logic [REG_IDX_W-1:0] REG_D = 7'h0D;

    localparam logic [7:0] VALID_POWER_BYTE = 8'h80;

    // event/flag/enable triple, ordered as bits 6,5,4 of registers B and C
    typedef struct packed {
        logic periodic;
        logic alarm;
        logic update;
    } rtc_evt_t;

    function automatic logic [7:0] flag_byte(rtc_evt_t flags, rtc_evt_t en);
        logic [2:0] live;
        live = flags & en;
        return {|live, flags, 4'b0000};
    endfunction

endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/rtc_byte_bank.sv
module rtc_byte_bank #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rtc_evt_t evt,
    input  rtc_evt_t en,
    input  logic     rd_clr,
    output rtc_evt_t flags,
    output logic     irq
);
    rtc_evt_t flags_d;

    // a read clears the held flags; a coincident event still lands
    always_comb begin
        flags_d = rd_clr ? rtc_evt_t'(3'b000) : flags;
        flags_d = flags_d | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

    assign irq = |(flags & en);

    assert_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && evt == '0) |=> (flags == '0));

    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr && evt == '0) |=> $stable(flags));
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_port_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_DEPTH = 128,
    localparam int PA_W = $clog2(2 * NUM_BANKS),
    localparam int BS_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW   = $clog2(BANK_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PA_W-1:0] bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            uip_i,
    input  logic            ev_periodic_i,
    input  logic            ev_alarm_i,
    input  logic            ev_update_i,
    output logic [6:0]      ctrl_a_o,
    output logic [7:0]      ctrl_b_o,
    output logic            irq_o
);
    logic [7:0]      idx_q   [NUM_BANKS];
    logic [7:0]      bank_rd [NUM_BANKS];
    logic [BS_W-1:0] bank_sel;
    logic            is_data;

    assign is_data  = bus_addr[0];
    assign bank_sel = BS_W'(bus_addr[PA_W-1:1]);

    // window-0 decode
    logic [AW-1:0] w0_idx;
    logic          w0_data_hit, sel_a, sel_b, sel_c, sel_d, rd_clr;
    logic [6:0]    ctrl_a_q;
    logic [7:0]    ctrl_b_q;
    rtc_evt_t      flags, evt_in;
    logic          irq;

    assign w0_idx      = idx_q[0][AW-1:0];
    assign w0_data_hit = (bus_addr == PA_W'(1));
    assign sel_a       = (w0_idx == AW'(REG_A));
    assign sel_b       = (w0_idx == AW'(REG_B));
    assign sel_c       = (w0_idx == AW'(REG_C));
    assign sel_d       = (w0_idx == AW'(REG_D));
    assign rd_clr      = bus_rd && w0_data_hit && sel_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
        end else if (bus_wr && w0_data_hit) begin
            if (sel_a) ctrl_a_q <= bus_wdata[6:0];
            if (sel_b) ctrl_b_q <= bus_wdata;
        end
    end

    assign evt_in = '{periodic: ev_periodic_i, alarm: ev_alarm_i, update: ev_update_i};

    rtc_flag_unit u_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_in),
        .en     (rtc_evt_t'(ctrl_b_q[6:4])),
        .rd_clr (rd_clr),
        .flags  (flags),
        .irq    (irq)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_win
            logic          idx_we, dat_hit, mem_we;
            logic [7:0]    mem_rd;
            logic [AW-1:0] widx;

            assign idx_we  = bus_wr && (bus_addr == PA_W'(2 * b));
            assign dat_hit = (bus_addr == PA_W'(2 * b + 1));
            assign widx    = idx_q[b][AW-1:0];

            rtc_index_reg #(.W(8)) u_idx (
                .clk (clk),
                .rst (rst),
                .we  (idx_we),
                .d   (bus_wdata),
                .q   (idx_q[b])
            );

            if (b == 0) begin : g_ctl
                // A..D live in dedicated logic; the array ignores them
                assign mem_we = bus_wr && dat_hit && !(sel_a || sel_b || sel_c || sel_d);
                always_comb begin
                    if (sel_a)      bank_rd[b] = {uip_i, ctrl_a_q};
                    else if (sel_b) bank_rd[b] = ctrl_b_q;
                    else if (sel_c) bank_rd[b] = flag_byte(flags, rtc_evt_t'(ctrl_b_q[6:4]));
                    else if (sel_d) bank_rd[b] = VALID_POWER_BYTE;
                    else            bank_rd[b] = mem_rd;
                end
            end else begin : g_ext
                assign mem_we     = bus_wr && dat_hit;
                assign bank_rd[b] = mem_rd;
            end

            rtc_byte_bank #(.DEPTH(BANK_DEPTH)) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (mem_we),
                .waddr (widx),
                .wdata (bus_wdata),
                .raddr (widx),
                .rdata (mem_rd)
            );
        end
    endgenerate

    assign bus_rdata = is_data ? bank_rd[bank_sel] : idx_q[bank_sel];
    assign ctrl_a_o  = ctrl_a_q;
    assign ctrl_b_o  = ctrl_b_q;
    assign irq_o     = irq;

    assert_irqbit_R4: assert property (@(posedge clk) disable iff (rst)
        (w0_data_hit && sel_c) |-> (bus_rdata[7] == irq_o));

    assert_regd_R7: assert property (@(posedge clk) disable iff (rst)
        (w0_data_hit && sel_d) |-> (bus_rdata == 8'h80));

    assert_uip_R8: assert property (@(posedge clk) disable iff (rst)
        (w0_data_hit && sel_a) |-> (bus_rdata[7] == uip_i));

    assert_cd_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && w0_data_hit && sel_c) |=> $stable(ctrl_b_o));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == 1'b0 && ctrl_b_o == 8'h00 && ctrl_a_o == 7'h00));
endmodule

// File: tb/sim_rtc_host_port.sv
`timescale 1ns/1ps
module sim_rtc_host_port;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       uip_i, ev_p, ev_a, ev_u;
    logic [6:0] ctrl_a_o;
    logic [7:0] ctrl_b_o;
    logic       irq_o;

    always #2.5 clk = ~clk;

    rtc_host_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uip_i(uip_i),
        .ev_periodic_i(ev_p), .ev_alarm_i(ev_a), .ev_update_i(ev_u),
        .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .irq_o(irq_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    logic [7:0] m0 [128];
    logic [7:0] m1 [128];
    logic [2:0] mflags;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_w0(input logic [7:0] idx);
        logic [6:0] i;
        i = idx[6:0];
        case (i)
            7'h0A: return {uip_i, m0[i][6:0]};
            7'h0C: return {|(mflags & m0[7'h0B][6:4]), mflags, 4'b0000};
            7'h0D: return 8'h80;
            default: return m0[i];
        endcase
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic w0_write(input logic [7:0] idx, input logic [7:0] d);
        logic [6:0] i;
        i = idx[6:0];
        bus_write(2'd0, idx);
        bus_write(2'd1, d);
        if (i == 7'h0A)                   m0[i] = {1'b0, d[6:0]};
        else if (i != 7'h0C && i != 7'h0D) m0[i] = d;
    endtask

    task automatic w1_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(2'd2, idx);
        bus_write(2'd3, d);
        m1[idx[6:0]] = d;
    endtask

    task automatic w0_read(input logic [7:0] idx, output logic [7:0] d);
        bus_write(2'd0, idx);
        bus_read(2'd1, d);
    endtask

    task automatic pulse(input logic [2:0] e);
        @(negedge clk);
        {ev_p, ev_a, ev_u} = e;
        @(posedge clk); #1;
        {ev_p, ev_a, ev_u} = 3'b000;
        mflags = mflags | e;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, idx, wd;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
        mflags = 3'b000;
        rst = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        uip_i = 1'b0; ev_p = 1'b0; ev_a = 1'b0; ev_u = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        check("R10 irq", {7'b0, irq_o}, 8'h00);
        check("R10 ctrl_b", ctrl_b_o, 8'h00);
        check("R10 ctrl_a", {1'b0, ctrl_a_o}, 8'h00);
        bus_read(2'd0, d); check("R10 index0", d, 8'h00);
        bus_read(2'd2, d); check("R10 index1", d, 8'h00);

        // R1 window-0 write/read and index readback
        w0_write(8'h20, 8'h5A);
        bus_read(2'd0, d); check("R1 index readback", d, 8'h20);
        w0_read(8'h20, d); check("R1 data", d, 8'h5A);

        // R2 window 1 separate
        w1_write(8'h20, 8'hC3);
        bus_read(2'd2, d); check("R2 index1 readback", d, 8'h20);
        bus_read(2'd3, d); check("R2 data1", d, 8'hC3);
        w0_read(8'h20, d); check("R2 window0 untouched", d, 8'h5A);

        // R9 RAM top and index bit 7 alias
        w0_write(8'h7F, 8'hE1);
        w0_read(8'h7F, d); check("R9 ram 0x7F", d, 8'hE1);
        w0_read(8'hA0, d); check("R9 alias 0xA0", d, 8'h5A);
        w0_write(8'h8F, 8'h3C);
        w0_read(8'h0F, d); check("R9 alias write 0x0F", d, 8'h3C);

        // R8 register A bit 7 from uip_i, B drives output
        w0_write(8'h0A, 8'hFF);
        w0_read(8'h0A, d); check("R8 A uip=0", d, 8'h7F);
        uip_i = 1'b1;
        w0_read(8'h0A, d); check("R8 A uip=1", d, 8'hFF);
        uip_i = 1'b0;
        check("R8 ctrl_a_o", {1'b0, ctrl_a_o}, 8'h7F);
        w0_write(8'h0B, 8'h00);
        check("R8 ctrl_b_o", ctrl_b_o, 8'h00);

        // R3 alarm latched while disabled
        pulse(3'b010);
        @(negedge clk); check("R3 irq stays low", {7'b0, irq_o}, 8'h00);
        w0_read(8'h0C, d); check("R3 alarm flag", d, 8'h20);
        mflags = 3'b000;
        // R5 cleared by the read
        w0_read(8'h0C, d); check("R5 cleared", d, 8'h00);

        // R4 enabled periodic raises irq and bit 7
        w0_write(8'h0B, 8'h40);
        check("R8 ctrl_b_o 0x40", ctrl_b_o, 8'h40);
        pulse(3'b100);
        @(negedge clk); check("R4 irq high", {7'b0, irq_o}, 8'h01);
        w0_read(8'h0C, d); check("R4 bit7 set", d, 8'hC0);
        mflags = 3'b000;
        @(negedge clk); check("R4 irq low after read", {7'b0, irq_o}, 8'h00);

        // R6 event during a read of C
        bus_write(2'd0, 8'h0C);
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1; ev_u = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; ev_u = 1'b0;
        check("R6 read during event", d, 8'h00);
        bus_read(2'd1, d); check("R6 event kept", d, 8'h10);

        // R7 writes to C and D ignored; D reads 0x80
        pulse(3'b010);
        bus_write(2'd0, 8'h0C); bus_write(2'd1, 8'h00);
        w0_read(8'h0C, d); check("R7 C write ignored", d, 8'h20);
        mflags = 3'b000;
        w0_write(8'h0D, 8'h00);
        w0_read(8'h0D, d); check("R7 D reads 0x80", d, 8'h80);
        check("R7 B unchanged", ctrl_b_o, 8'h40);

        // random mix
        for (int k = 0; k < 400; k++) begin
            idx = 8'($urandom);
            wd  = 8'($urandom);
            uip_i = 1'($urandom);
            case ($urandom % 5)
                0: w0_write(idx, wd);
                1: w1_write(idx, wd);
                2: begin
                    w0_read(idx, d);
                    check("R1 random window0", d, exp_w0(idx));
                    if (idx[6:0] == 7'h0C) mflags = 3'b000;
                end
                3: begin
                    bus_write(2'd2, idx); bus_read(2'd3, d);
                    check("R2 random window1", d, m1[idx[6:0]]);
                end
                default: begin
                    pulse(3'($urandom));
                    @(negedge clk);
                    check("R4 random irq", {7'b0, irq_o},
                          {7'b0, |(mflags & m0[7'h0B][6:4])});
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule